// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of recent virtual-to-physical translations. A lookup presents a 32-bit virtual address and the current 8-bit address space ID. In the same cycle the block answers with a hit flag, the physical address and the page size of the matching entry. No memory access is made on a hit. When a lookup misses, the block raises a walk request. The table walker, which sits outside this block, later returns the translation as a fill. The fill carries the virtual address, the page base, the page size, a global flag and the ASID, and it is stored for reuse.

Each entry holds either a global mapping or a mapping private to one ASID. A private entry answers only under its own ASID, so several tasks can keep live translations of the same virtual page at the same time. Switching the current ASID therefore needs no flush. Software maintenance is done through two commands: one clears the whole buffer, the other removes every entry whose range covers a given address.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid. Every lookup misses until a fill has been accepted.
- R2: On a hit, in the cycle of the lookup, `pa_o` is formed from the entry's page base above the page size and the lookup address below it. `size_o` gives the entry's page size.
- R3: `walk_req_o` is high exactly when a lookup is presented and misses. With no lookup, both `hit_o` and `walk_req_o` are low.
- R4: A fill changes lookup results only from the cycle after it is presented. A lookup in the same cycle as the fill sees the old contents.
- R5: A non-global entry stores the fill ASID and hits only when `cur_asid_i` equals that stored ASID.
- R6: A global entry (`fill_global_i`=1) hits under any value of `cur_asid_i`.
- R7: Non-global entries for the same virtual page under different ASIDs coexist. Each one returns its own physical address.
- R8: Size encoding is 0=4KB, 1=64KB, 2=1MB, 3=16MB. The tag compare uses only the virtual address bits at and above the page size: bit 12, 16, 20 or 24 up to bit 31.
- R9: A fill goes to an invalid entry while one exists. Eight fills into an empty buffer therefore evict nothing.
- R10: When all 8 entries are valid, a fill replaces entries in round-robin order. The order starts at entry 0 after reset and advances only on such replacements. With the fill order used here, the first replacement evicts the entry written first into entry 0.
- R11: `inv_all_i` invalidates every entry in the next cycle. It overrides a fill presented in the same cycle, and that fill is dropped.
- R12: `inv_va_valid_i` removes every entry whose range covers `inv_va_i`, whatever its ASID or global flag, and leaves other entries alone. A fill presented in the same cycle is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_va_i | input | 32 | Lookup virtual address |
| cur_asid_i | input | 8 | Current address space ID |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | 32 | Translated physical address (zero on miss) |
| size_o | output | 2 | Page size of the hit entry |
| walk_req_o | output | 1 | Lookup missed; a table walk is needed |
| fill_valid_i | input | 1 | Write a translation |
| fill_va_i | input | 32 | Virtual address of the fill |
| fill_pa_i | input | 32 | Physical page base of the fill |
| fill_size_i | input | 2 | Page size of the fill |
| fill_global_i | input | 1 | Fill is global |
| fill_asid_i | input | 8 | ASID stored with a non-global fill |
| inv_all_i | input | 1 | Invalidate all entries |
| inv_va_valid_i | input | 1 | Invalidate entries covering `inv_va_i` |
| inv_va_i | input | 32 | Address for the targeted invalidate |

## Verification
Lookups are combinational on registered state, so a corrupted tag, ASID or size field shows at `hit_o`, `pa_o` or `size_o` on the first lookup that touches the entry. Such a fault appears as a wrong hit or miss, or as the wrong bits taken from the page base or the offset. A wrong replacement pointer or a faulty free-slot choice is invisible until the buffer is full. It then appears one cycle after the offending fill, as a lookup that misses on a translation that should have survived. Invalidate faults are visible on the cycle right after the command, through lookups at covered and uncovered addresses under several ASIDs.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  parameter int VA_W   = 32;
  parameter int OFF_W  = 12;
  parameter int PN_W   = VA_W - OFF_W;
  parameter int ASID_W = 8;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              valid;
    logic              global;
    logic [ASID_W-1:0] asid;
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   ppn;
    pg_size_e          size;
  } tlb_entry_t;

  // page-number bits that take part in the tag: each size step drops 4 bits
  function automatic logic [PN_W-1:0] pn_mask(pg_size_e s);
    return {PN_W{1'b1}} << (4 * int'(s));
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import asid_tlb_pkg::*;
(
  input  tlb_entry_t        entry_i,
  input  logic [PN_W-1:0]   pn_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              any_asid_i,
  output logic              match_o
);
  logic [PN_W-1:0] mask;
  logic            tag_eq;
  logic            asid_ok;

  always_comb begin
    mask    = pn_mask(entry_i.size);
    tag_eq  = ((pn_i & mask) == (entry_i.vpn & mask));
    asid_ok = any_asid_i || entry_i.global || (entry_i.asid == asid_i);
    match_o = entry_i.valid && tag_eq && asid_ok;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               fill_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
    idx_o = any_free ? free_idx : rr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_i && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VA_W-1:0]   lookup_va_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              hit_o,
  output logic [VA_W-1:0]   pa_o,
  output logic [1:0]        size_o,
  output logic              walk_req_o,
  input  logic              fill_valid_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [VA_W-1:0]   fill_pa_i,
  input  logic [1:0]        fill_size_i,
  input  logic              fill_global_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              inv_all_i,
  input  logic              inv_va_valid_i,
  input  logic [VA_W-1:0]   inv_va_i
);
  tlb_entry_t         ent_q [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] inv_match;
  logic [IDX_W-1:0]   victim;
  logic [IDX_W-1:0]   hit_idx;
  logic               any_hit;
  tlb_entry_t         hit_ent;
  tlb_entry_t         new_ent;
  logic [PN_W-1:0]    hmask;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign valid_vec[g] = ent_q[g].valid;

    tlb_match i_lk (
      .entry_i   (ent_q[g]),
      .pn_i      (lookup_va_i[VA_W-1:OFF_W]),
      .asid_i    (cur_asid_i),
      .any_asid_i(1'b0),
      .match_o   (lk_match[g])
    );

    tlb_match i_inv (
      .entry_i   (ent_q[g]),
      .pn_i      (inv_va_i[VA_W-1:OFF_W]),
      .asid_i    (cur_asid_i),
      .any_asid_i(1'b1),
      .match_o   (inv_match[g])
    );
  end

  tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_vec),
    .fill_i (fill_valid_i && !inv_all_i),
    .idx_o  (victim)
  );

  // lowest matching index wins if two entries overlap
  always_comb begin
    hit_idx = '0;
    any_hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
    hit_ent    = ent_q[hit_idx];
    hmask      = pn_mask(hit_ent.size);
    hit_o      = lookup_valid_i && any_hit;
    walk_req_o = lookup_valid_i && !any_hit;
    size_o     = hit_o ? hit_ent.size : 2'd0;
    pa_o       = hit_o ? {(hit_ent.ppn & hmask) | (lookup_va_i[VA_W-1:OFF_W] & ~hmask),
                          lookup_va_i[OFF_W-1:0]}
                       : '0;
  end

  always_comb begin
    new_ent.valid  = 1'b1;
    new_ent.global = fill_global_i;
    new_ent.asid   = fill_global_i ? '0 : fill_asid_i;
    new_ent.size   = pg_size_e'(fill_size_i);
    new_ent.vpn    = fill_va_i[VA_W-1:OFF_W] & pn_mask(pg_size_e'(fill_size_i));
    new_ent.ppn    = fill_pa_i[VA_W-1:OFF_W] & pn_mask(pg_size_e'(fill_size_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (inv_all_i) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_va_valid_i && inv_match[i]) ent_q[i].valid <= 1'b0;
      end
      // fill written last so it survives a same-cycle targeted invalidate
      if (fill_valid_i) ent_q[victim] <= new_ent;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lookup_valid_i,
  input logic [31:0] lookup_va_i,
  input logic [7:0]  cur_asid_i,
  input logic        hit_o,
  input logic [31:0] pa_o,
  input logic [1:0]  size_o,
  input logic        walk_req_o,
  input logic        fill_valid_i,
  input logic [31:0] fill_va_i,
  input logic        fill_global_i,
  input logic [7:0]  fill_asid_i,
  input logic        inv_all_i,
  input logic        inv_va_valid_i,
  input logic [31:0] inv_va_i
);
  assert_hit_needs_lookup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || walk_req_o) |-> lookup_valid_i);

  assert_hit_walk_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && walk_req_o));

  assert_offset_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[11:0] == lookup_va_i[11:0]);

  assert_big_page_offset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && size_o == 2'd3) |-> pa_o[23:0] == lookup_va_i[23:0]);

  assert_flush_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> !hit_o);

  assert_fill_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_valid_i && !inv_all_i) && lookup_valid_i
     && lookup_va_i == $past(fill_va_i)
     && ($past(fill_global_i) || cur_asid_i == $past(fill_asid_i))) |-> hit_o);

  assert_inv_va_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(inv_va_valid_i && !fill_valid_i) && lookup_valid_i
     && lookup_va_i == $past(inv_va_i)) |-> !hit_o);
endmodule

bind asid_tlb asid_tlb_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lookup_valid_i(lookup_valid_i),
  .lookup_va_i   (lookup_va_i),
  .cur_asid_i    (cur_asid_i),
  .hit_o         (hit_o),
  .pa_o          (pa_o),
  .size_o        (size_o),
  .walk_req_o    (walk_req_o),
  .fill_valid_i  (fill_valid_i),
  .fill_va_i     (fill_va_i),
  .fill_global_i (fill_global_i),
  .fill_asid_i   (fill_asid_i),
  .inv_all_i     (inv_all_i),
  .inv_va_valid_i(inv_va_valid_i),
  .inv_va_i      (inv_va_i)
);

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_va_i = '0;
  logic [7:0]  cur_asid_i = '0;
  logic        hit_o;
  logic [31:0] pa_o;
  logic [1:0]  size_o;
  logic        walk_req_o;
  logic        fill_valid_i = 1'b0;
  logic [31:0] fill_va_i = '0;
  logic [31:0] fill_pa_i = '0;
  logic [1:0]  fill_size_i = '0;
  logic        fill_global_i = 1'b0;
  logic [7:0]  fill_asid_i = '0;
  logic        inv_all_i = 1'b0;
  logic        inv_va_valid_i = 1'b0;
  logic [31:0] inv_va_i = '0;

  always #2 clk_i = ~clk_i;

  asid_tlb i_asid_tlb (.*);

  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic [1:0]  size;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  // pending controls applied by the next step
  logic        p_fill = 0, p_glob = 0, p_iall = 0, p_iva = 0;
  logic [31:0] p_fva = 0, p_fpa = 0, p_ia = 0;
  logic [1:0]  p_fsz = 0;
  logic [7:0]  p_fasid = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                      input logic g, input logic [7:0] a);
    p_fill = 1; p_fva = va; p_fpa = pa; p_fsz = sz; p_glob = g; p_fasid = a;
  endtask

  task automatic step(input bit lk, input logic [31:0] va, input logic [7:0] asid,
                      input logic eh, input logic [31:0] epa, input logic [1:0] esz, input string tag);
    exp_t e;
    @(posedge clk_i); #1;
    lookup_valid_i = lk; lookup_va_i = va; cur_asid_i = asid;
    fill_valid_i = p_fill; fill_va_i = p_fva; fill_pa_i = p_fpa; fill_size_i = p_fsz;
    fill_global_i = p_glob; fill_asid_i = p_fasid;
    inv_all_i = p_iall; inv_va_valid_i = p_iva; inv_va_i = p_ia;
    p_fill = 0; p_iall = 0; p_iva = 0;
    if (lk) begin
      e.hit = eh; e.pa = eh ? epa : 32'h0; e.size = eh ? esz : 2'd0; e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, "");
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (lookup_valid_i) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          check(0, "scoreboard empty", 0, 0);
        end else begin
          e = exp_q.pop_front();
          check(hit_o == e.hit, {e.tag, " hit"}, 64'(hit_o), 64'(e.hit));
          check(walk_req_o == !e.hit, {e.tag, " walk_req R3"}, 64'(walk_req_o), 64'(!e.hit));
          check(pa_o == e.pa, {e.tag, " pa"}, 64'(pa_o), 64'(e.pa));
          check(size_o == e.size, {e.tag, " size"}, 64'(size_o), 64'(e.size));
        end
      end else begin
        check(!hit_o && !walk_req_o, "R3 idle outputs", 64'({hit_o, walk_req_o}), 0);
      end
    end
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    idle();
    step(1, 32'h0000_1000, 8'd1, 0, 0, 0, "R1 reset miss");
    step(1, 32'h7700_0000, 8'd0, 0, 0, 0, "R1 reset miss 2");

    fill(32'h0001_2000, 32'h8000_5000, 2'd0, 0, 8'd1);
    step(1, 32'h0001_2345, 8'd1, 0, 0, 0, "R4 same-cycle fill not seen");
    step(1, 32'h0001_2345, 8'd1, 1, 32'h8000_5345, 2'd0, "R2 R4 hit after fill");
    step(1, 32'h0001_2345, 8'd2, 0, 0, 0, "R5 other asid miss");

    fill(32'h0001_2000, 32'h9000_7000, 2'd0, 0, 8'd2);
    idle();
    step(1, 32'h0001_2345, 8'd2, 1, 32'h9000_7345, 2'd0, "R7 asid2 own pa");
    step(1, 32'h0001_2345, 8'd1, 1, 32'h8000_5345, 2'd0, "R7 asid1 own pa");

    fill(32'h0040_0000, 32'hA012_0000, 2'd1, 1, 8'd5);
    idle();
    step(1, 32'h0040_ABCD, 8'd9, 1, 32'hA012_ABCD, 2'd1, "R6 R8 global 64K");
    step(1, 32'h0041_0000, 8'd9, 0, 0, 0, "R8 outside 64K");

    fill(32'h1230_0000, 32'h4560_0000, 2'd2, 0, 8'd3);
    idle();
    step(1, 32'h123F_FFFC, 8'd3, 1, 32'h456F_FFFC, 2'd2, "R8 1M");

    fill(32'h7700_0000, 32'h2F00_0000, 2'd3, 1, 8'd0);
    idle();
    step(1, 32'h77AB_CDEF, 8'd0, 1, 32'h2FAB_CDEF, 2'd3, "R8 16M");

    p_iva = 1; p_ia = 32'h0001_2FFF;
    idle();
    step(1, 32'h0001_2345, 8'd1, 0, 0, 0, "R12 asid1 removed");
    step(1, 32'h0001_2345, 8'd2, 0, 0, 0, "R12 asid2 removed");
    step(1, 32'h0040_0000, 8'd4, 1, 32'hA012_0000, 2'd1, "R12 other kept");

    p_iva = 1; p_ia = 32'h1234_5678;
    fill(32'h1234_5000, 32'h3333_3000, 2'd0, 1, 8'd0);
    idle();
    step(1, 32'h1230_0010, 8'd3, 0, 0, 0, "R12 1M removed");
    step(1, 32'h1234_5678, 8'd3, 1, 32'h3333_3678, 2'd0, "R12 same-cycle fill kept");

    for (int i = 0; i < 5; i++) begin
      fill(32'h0100_0000 + i * 32'h1000, 32'h5000_0000 + i * 32'h1000, 2'd0, 0, 8'd0);
      idle();
    end
    idle();
    step(1, 32'h1234_5678, 8'd7, 1, 32'h3333_3678, 2'd0, "R9 slot kept");
    step(1, 32'h0040_1111, 8'd7, 1, 32'hA012_1111, 2'd1, "R9 slot kept");
    step(1, 32'h7712_3456, 8'd7, 1, 32'h2F12_3456, 2'd3, "R9 slot kept");
    for (int i = 0; i < 5; i++) begin
      step(1, 32'h0100_0010 + i * 32'h1000, 8'd0, 1, 32'h5000_0010 + i * 32'h1000, 2'd0, "R9 fill kept");
    end

    fill(32'h0200_0000, 32'h6000_0000, 2'd0, 0, 8'd0);
    idle();
    step(1, 32'h1234_5678, 8'd3, 0, 0, 0, "R10 entry0 evicted");
    step(1, 32'h0200_0004, 8'd0, 1, 32'h6000_0004, 2'd0, "R10 new hit");
    step(1, 32'h0100_0000, 8'd0, 1, 32'h5000_0000, 2'd0, "R10 entry1 kept");

    fill(32'h0200_1000, 32'h6000_1000, 2'd0, 0, 8'd0);
    idle();
    step(1, 32'h0100_0000, 8'd0, 0, 0, 0, "R10 entry1 evicted");
    step(1, 32'h0040_0000, 8'd0, 1, 32'hA012_0000, 2'd1, "R10 entry2 kept");

    p_iall = 1;
    fill(32'h0300_0000, 32'h7000_0000, 2'd0, 1, 8'd0);
    idle();
    step(1, 32'h0300_0000, 8'd0, 0, 0, 0, "R11 fill dropped");
    step(1, 32'h0200_0000, 8'd0, 0, 0, 0, "R11 flushed");
    step(1, 32'h7700_0000, 8'd0, 0, 0, 0, "R11 flushed global");
    idle();
    idle();

    check(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule